// File: doc/BRIEF.md
# UART interrupt generation unit

This block sits beside the transmit path, the receive FIFO and the modem-status logic of a UART. From their status flags it builds six interrupt sources. The transmitter has two: hold register empty and transmission complete. The receiver has three: data ready, receive timeout and line status. The modem-status logic has one. The block keeps event sources pending until the matching software access clears them. It measures how long the receive FIFO has been idle, in bit times, to detect the timeout. It then applies one enable bit per group.

Two outputs leave the block. A single interrupt line goes high when any enabled source is pending. A three-bit identification code names the highest-priority enabled source, so the interrupt handler can read one value and jump straight to the right service routine. Flags that arrive as pulses (shift done, error flags, modem changes, register strobes) are one clock wide. The level inputs (FIFO count, trigger level, hold empty) are sampled every cycle.

Top module: `uart_irq_ctrl`

## Requirements
- R1: While reset is active and after it is released with no events, `irq_o` is 0 and `irq_id_o` is 3'd0 (nothing pending).
- R2: A 0-to-1 change of `hold_empty_i` makes the hold-empty source pending from the next clock edge. It stays pending until a `thr_wr_i` strobe.
- R3: A `shift_done_i` pulse makes the transmission-complete source pending from the next clock edge. A `thr_wr_i` strobe clears both transmitter sources.
- R4: With `fifo_en_i`=1, data ready is pending in the same cycle whenever `rx_count_i` >= `trig_lvl_i`. The trigger level must be at least 1.
- R5: With `fifo_en_i`=0, data ready is pending in the same cycle whenever `rx_count_i` is non-zero.
- R6: With `fifo_en_i`=1 and 0 < `rx_count_i` < `trig_lvl_i`, the timeout becomes pending once 4×`frame_bits_i` `bit_tick_i` pulses have passed with no `fifo_wr_i` or `rbr_rd_i` strobe. It is visible one clock edge after the last of those ticks. Any such strobe restarts the count.
- R7: Once pending, the timeout stays pending while `rx_count_i` is non-zero, even across reads. It clears on the first clock edge at which the count is zero.
- R8: A pulse on any of `par_err_i`, `frm_err_i`, `ovr_err_i` or `brk_i` makes line status pending from the next edge. An `lsr_rd_i` strobe clears it.
- R9: When `nine_bit_i`=1, a `par_err_i` pulse marks an address byte and does not make line status pending.
- R10: A pulse on any bit of `msc_i` makes modem status pending from the next edge. An `msr_rd_i` strobe clears it.
- R11: `en_i` gates the sources and `irq_o` is the OR of the enabled pending sources. The bits of `en_i` are: bit0 data ready and timeout together, bit1 hold empty, bit2 transmission complete, bit3 line status, bit4 modem status. A disabled source stays pending and appears as soon as its bit is set.
- R12: `irq_id_o` reports the highest enabled pending source. The codes, from highest priority to lowest, are: 1 line status, 2 data ready, 3 timeout, 4 hold empty, 5 transmission complete, 6 modem status. 0 means none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en_i | input | 5 | Group enable bits (see R11) |
| fifo_en_i | input | 1 | Receive FIFO mode enabled |
| nine_bit_i | input | 1 | 9-bit character mode (parity marks address) |
| trig_lvl_i | input | CNT_W | Receive FIFO trigger level |
| rx_count_i | input | CNT_W | Bytes currently in the receive FIFO or buffer |
| frame_bits_i | input | FRAME_W | Character length in bit times |
| bit_tick_i | input | 1 | One pulse per bit time |
| hold_empty_i | input | 1 | Transmit hold register empty (level) |
| shift_done_i | input | 1 | Transmit shift register finished (pulse) |
| par_err_i | input | 1 | Parity mismatch on received byte (pulse) |
| frm_err_i | input | 1 | Missing stop bit (pulse) |
| ovr_err_i | input | 1 | Receiver overrun (pulse) |
| brk_i | input | 1 | Break detected (pulse) |
| msc_i | input | MSC_W | Modem-status change flags (pulses) |
| thr_wr_i | input | 1 | Write strobe of transmit hold register |
| rbr_rd_i | input | 1 | Read strobe of receive buffer |
| fifo_wr_i | input | 1 | Receive FIFO write strobe |
| lsr_rd_i | input | 1 | Read strobe of line-status register |
| msr_rd_i | input | 1 | Read strobe of modem-status register |
| irq_o | output | 1 | Combined interrupt request |
| irq_id_o | output | 3 | Code of highest-priority enabled pending source |

## Verification
A latch that fails to set or clear shows up on `irq_id_o` one clock edge after the triggering pulse or strobe, because every source feeds the code directly. A wrong idle count moves the moment the timeout code 3 appears away from one edge after the 4×frame-length tick. A wrong restart or clear condition either leaves code 3 showing after the FIFO drains or lets it drop while bytes remain. Priority or enable mistakes appear in the same cycle, as a different code when several sources are pending at once.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  typedef enum logic [2:0] {
    ID_NONE  = 3'd0,
    ID_LINE  = 3'd1,
    ID_RDY   = 3'd2,
    ID_TMO   = 3'd3,
    ID_THRE  = 3'd4,
    ID_TXC   = 3'd5,
    ID_MODEM = 3'd6
  } irq_id_e;

  localparam int EN_W     = 5;
  localparam int EN_RX    = 0;
  localparam int EN_THRE  = 1;
  localparam int EN_TXC   = 2;
  localparam int EN_LINE  = 3;
  localparam int EN_MODEM = 4;

  localparam int NSTICKY  = 4;
  localparam int S_THRE   = 0;
  localparam int S_TXC    = 1;
  localparam int S_LINE   = 2;
  localparam int S_MODEM  = 3;
endpackage

// File: rtl/uart_irq_sticky.sv
module uart_irq_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  logic pend_q, pend_d;

  always_comb begin
    pend_d = pend_q;
    if (clr_i) pend_d = 1'b0;
    if (set_i) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/uart_irq_rx_tmo.sv
module uart_irq_rx_tmo #(
  parameter int CNT_W   = 5,
  parameter int FRAME_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fifo_en_i,
  input  logic [CNT_W-1:0]   rx_count_i,
  input  logic [CNT_W-1:0]   trig_lvl_i,
  input  logic [FRAME_W-1:0] frame_bits_i,
  input  logic               bit_tick_i,
  input  logic               access_i,
  output logic               tmo_o
);
  localparam int IDLE_W = FRAME_W + 2;

  logic [IDLE_W-1:0] idle_q, idle_d, limit;
  logic              tmo_q, tmo_d;
  logic              empty, below, idle_en;

  always_comb begin
    limit   = {frame_bits_i, 2'b00};
    empty   = (rx_count_i == '0);
    below   = (rx_count_i < trig_lvl_i);
    idle_en = empty | access_i | (bit_tick_i & (idle_q < limit));
    idle_d  = idle_q;
    if (empty || access_i)
      idle_d = '0;
    else if (bit_tick_i && (idle_q < limit))
      idle_d = idle_q + 1'b1;

    tmo_d = tmo_q;
    if (empty)
      tmo_d = 1'b0;
    else if (fifo_en_i && below && !access_i && (limit != '0) && (idle_q >= limit))
      tmo_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       idle_q <= '0;
    else if (idle_en) idle_q <= idle_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmo_q <= 1'b0;
    else        tmo_q <= tmo_d;
  end

  assign tmo_o = tmo_q;

  p_tmo_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_o && rx_count_i != '0) |=> tmo_o);
  p_tmo_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count_i == '0) |=> !tmo_o);
  p_tmo_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_o) |-> $past(!access_i && fifo_en_i));
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic            line_i,
  input  logic            rdy_i,
  input  logic            tmo_i,
  input  logic            thre_i,
  input  logic            txc_i,
  input  logic            modem_i,
  input  logic [EN_W-1:0] en_i,
  output logic            irq_o,
  output irq_id_e         id_o
);
  logic l_en, r_en, t_en, h_en, c_en, m_en;

  always_comb begin
    l_en = line_i  & en_i[EN_LINE];
    r_en = rdy_i   & en_i[EN_RX];
    t_en = tmo_i   & en_i[EN_RX];
    h_en = thre_i  & en_i[EN_THRE];
    c_en = txc_i   & en_i[EN_TXC];
    m_en = modem_i & en_i[EN_MODEM];
    irq_o = l_en | r_en | t_en | h_en | c_en | m_en;
    if (l_en)      id_o = ID_LINE;
    else if (r_en) id_o = ID_RDY;
    else if (t_en) id_o = ID_TMO;
    else if (h_en) id_o = ID_THRE;
    else if (c_en) id_o = ID_TXC;
    else if (m_en) id_o = ID_MODEM;
    else           id_o = ID_NONE;
  end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int FRAME_W    = 4,
  parameter int MSC_W      = 4,
  parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [EN_W-1:0]    en_i,
  input  logic               fifo_en_i,
  input  logic               nine_bit_i,
  input  logic [CNT_W-1:0]   trig_lvl_i,
  input  logic [CNT_W-1:0]   rx_count_i,
  input  logic [FRAME_W-1:0] frame_bits_i,
  input  logic               bit_tick_i,
  input  logic               hold_empty_i,
  input  logic               shift_done_i,
  input  logic               par_err_i,
  input  logic               frm_err_i,
  input  logic               ovr_err_i,
  input  logic               brk_i,
  input  logic [MSC_W-1:0]   msc_i,
  input  logic               thr_wr_i,
  input  logic               rbr_rd_i,
  input  logic               fifo_wr_i,
  input  logic               lsr_rd_i,
  input  logic               msr_rd_i,
  output logic               irq_o,
  output logic [2:0]         irq_id_o
);
  logic [1:0]         rst_pipe;
  logic               rst_sync_n;
  logic               hold_empty_q;
  logic               thre_rise, line_set, data_rdy, tmo_pend;
  logic [NSTICKY-1:0] s_set, s_clr, s_pend;
  irq_id_e            id;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) hold_empty_q <= 1'b0;
    else             hold_empty_q <= hold_empty_i;
  end

  always_comb begin
    thre_rise = hold_empty_i & ~hold_empty_q;
    line_set  = (par_err_i & ~nine_bit_i) | frm_err_i | ovr_err_i | brk_i;
    data_rdy  = fifo_en_i ? (rx_count_i >= trig_lvl_i) : (rx_count_i != '0);
    s_set          = '0;
    s_clr          = '0;
    s_set[S_THRE]  = thre_rise;
    s_clr[S_THRE]  = thr_wr_i;
    s_set[S_TXC]   = shift_done_i;
    s_clr[S_TXC]   = thr_wr_i;
    s_set[S_LINE]  = line_set;
    s_clr[S_LINE]  = lsr_rd_i;
    s_set[S_MODEM] = |msc_i;
    s_clr[S_MODEM] = msr_rd_i;
  end

  for (genvar g = 0; g < NSTICKY; g++) begin : g_src
    uart_irq_sticky u_flag (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .set_i  (s_set[g]),
      .clr_i  (s_clr[g]),
      .pend_o (s_pend[g])
    );
  end

  uart_irq_rx_tmo #(.CNT_W(CNT_W), .FRAME_W(FRAME_W)) u_tmo (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .fifo_en_i    (fifo_en_i),
    .rx_count_i   (rx_count_i),
    .trig_lvl_i   (trig_lvl_i),
    .frame_bits_i (frame_bits_i),
    .bit_tick_i   (bit_tick_i),
    .access_i     (fifo_wr_i | rbr_rd_i),
    .tmo_o        (tmo_pend)
  );

  uart_irq_prio u_prio (
    .line_i  (s_pend[S_LINE]),
    .rdy_i   (data_rdy),
    .tmo_i   (tmo_pend),
    .thre_i  (s_pend[S_THRE]),
    .txc_i   (s_pend[S_TXC]),
    .modem_i (s_pend[S_MODEM]),
    .en_i    (en_i),
    .irq_o   (irq_o),
    .id_o    (id)
  );

  assign irq_id_o = id;

  p_id_irq_r12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_o == (irq_id_o != ID_NONE));
  p_mask_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (en_i == '0) |-> !irq_o);
  p_tx_clear_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (thr_wr_i && !shift_done_i && !thre_rise) |=> (!s_pend[S_TXC] && !s_pend[S_THRE]));
  p_line_clear_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (lsr_rd_i && !frm_err_i && !ovr_err_i && !brk_i && !par_err_i) |=> !s_pend[S_LINE]);
  p_addr_byte_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (nine_bit_i && !frm_err_i && !ovr_err_i && !brk_i && !s_pend[S_LINE]) |=> !s_pend[S_LINE]);
  p_modem_clear_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (msr_rd_i && msc_i == '0) |=> !s_pend[S_MODEM]);
endmodule

// File: tb/sim_uart_irq_ctrl.sv
module sim_uart_irq_ctrl;
  localparam int CNT_W   = 5;
  localparam int FRAME_W = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic [4:0] en;
  logic fifo_en, nine_bit, tick, hold_empty, shift_done;
  logic par_err, frm_err, ovr_err, brk, thr_wr, rbr_rd, fifo_wr, lsr_rd, msr_rd;
  logic [CNT_W-1:0] trig, cnt;
  logic [FRAME_W-1:0] frame_bits;
  logic [3:0] msc;
  logic irq;
  logic [2:0] id;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  uart_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .en_i(en), .fifo_en_i(fifo_en), .nine_bit_i(nine_bit),
    .trig_lvl_i(trig), .rx_count_i(cnt), .frame_bits_i(frame_bits), .bit_tick_i(tick),
    .hold_empty_i(hold_empty), .shift_done_i(shift_done), .par_err_i(par_err),
    .frm_err_i(frm_err), .ovr_err_i(ovr_err), .brk_i(brk), .msc_i(msc),
    .thr_wr_i(thr_wr), .rbr_rd_i(rbr_rd), .fifo_wr_i(fifo_wr), .lsr_rd_i(lsr_rd),
    .msr_rd_i(msr_rd), .irq_o(irq), .irq_id_o(id)
  );

  // {fifo_en, count, trig, en, exp_irq, exp_id}
  localparam logic [19:0] VEC [0:6] = '{
    {1'b1, 5'd8,  5'd8,  5'b00001, 1'b1, 3'd2},  // R4 equal to trigger
    {1'b1, 5'd7,  5'd8,  5'b00001, 1'b0, 3'd0},  // R4 below trigger
    {1'b1, 5'd16, 5'd4,  5'b00001, 1'b1, 3'd2},  // R4 above trigger
    {1'b0, 5'd1,  5'd8,  5'b00001, 1'b1, 3'd2},  // R5 single byte
    {1'b0, 5'd0,  5'd8,  5'b00001, 1'b0, 3'd0},  // R5 empty
    {1'b1, 5'd8,  5'd8,  5'b00000, 1'b0, 3'd0},  // R11 masked
    {1'b0, 5'd3,  5'd15, 5'b11110, 1'b0, 3'd0}   // R11 rx bit off
  };

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic e_irq, input logic [2:0] e_id);
    checks++;
    if (irq !== e_irq || id !== e_id) begin
      errors++;
      $display("FAIL %s: irq=%0d id=%0d expected irq=%0d id=%0d", req, irq, id, e_irq, e_id);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(20 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: irq=%0d id=%0d expected irq=x id=x", irq, id);
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; en = '0; fifo_en = 0; nine_bit = 0; tick = 0; hold_empty = 0;
    shift_done = 0; par_err = 0; frm_err = 0; ovr_err = 0; brk = 0; thr_wr = 0;
    rbr_rd = 0; fifo_wr = 0; lsr_rd = 0; msr_rd = 0; trig = 5'd8; cnt = '0;
    frame_bits = 4'd10; msc = '0;
    step(); step();
    chk("R1 in reset", 1'b0, 3'd0);
    @(negedge clk) rst_n = 1'b1;
    step(); step(); step();
    en = 5'b11111;
    #1;
    chk("R1 after reset", 1'b0, 3'd0);

    for (int i = 0; i < 7; i++) begin
      fifo_en = VEC[i][19];
      cnt     = VEC[i][18:14];
      trig    = VEC[i][13:9];
      en      = VEC[i][8:4];
      #1;
      chk($sformatf("R4/R5/R11 vector %0d", i), VEC[i][3], VEC[i][2:0]);
      step();
    end
    cnt = '0; fifo_en = 1'b0; trig = 5'd8;

    // transmitter sources
    en = 5'b00010; hold_empty = 1'b1;
    step();
    chk("R2 hold empty rise", 1'b1, 3'd4);
    step();
    chk("R2 hold empty kept", 1'b1, 3'd4);
    thr_wr = 1'b1; hold_empty = 1'b0;
    step(); thr_wr = 1'b0;
    chk("R2 cleared by write", 1'b0, 3'd0);
    en = 5'b00100; shift_done = 1'b1;
    step(); shift_done = 1'b0;
    chk("R3 tx complete", 1'b1, 3'd5);
    en = 5'b00110; hold_empty = 1'b1;
    step();
    chk("R12 hold empty over tx complete", 1'b1, 3'd4);
    thr_wr = 1'b1; hold_empty = 1'b0;
    step(); thr_wr = 1'b0;
    chk("R3 write clears both", 1'b0, 3'd0);

    // line status
    en = 5'b01000; par_err = 1'b1;
    step(); par_err = 1'b0;
    chk("R8 parity", 1'b1, 3'd1);
    lsr_rd = 1'b1; step(); lsr_rd = 1'b0;
    chk("R8 cleared by status read", 1'b0, 3'd0);
    nine_bit = 1'b1; par_err = 1'b1;
    step(); par_err = 1'b0;
    chk("R9 address byte ignored", 1'b0, 3'd0);
    nine_bit = 1'b0;
    frm_err = 1'b1; step(); frm_err = 1'b0;
    chk("R8 framing", 1'b1, 3'd1);
    lsr_rd = 1'b1; step(); lsr_rd = 1'b0;
    ovr_err = 1'b1; step(); ovr_err = 1'b0;
    chk("R8 overrun", 1'b1, 3'd1);
    lsr_rd = 1'b1; step(); lsr_rd = 1'b0;
    brk = 1'b1; step(); brk = 1'b0;
    chk("R8 break", 1'b1, 3'd1);
    lsr_rd = 1'b1; step(); lsr_rd = 1'b0;
    chk("R8 cleared after break", 1'b0, 3'd0);

    // modem status
    en = 5'b10000; msc = 4'b0100;
    step(); msc = '0;
    chk("R10 modem change", 1'b1, 3'd6);
    msr_rd = 1'b1; step(); msr_rd = 1'b0;
    chk("R10 cleared by status read", 1'b0, 3'd0);

    // priority with several pending
    en = 5'b11111; brk = 1'b1; msc = 4'b0001; fifo_en = 1'b1; cnt = 5'd8;
    step(); brk = 1'b0; msc = '0;
    chk("R12 line first", 1'b1, 3'd1);
    lsr_rd = 1'b1; step(); lsr_rd = 1'b0;
    chk("R12 data ready next", 1'b1, 3'd2);
    cnt = '0; step();
    chk("R12 modem last", 1'b1, 3'd6);
    msr_rd = 1'b1; step(); msr_rd = 1'b0;
    chk("R12 none left", 1'b0, 3'd0);

    // masked source retained
    en = 5'b00000; brk = 1'b1; step(); brk = 1'b0;
    chk("R11 masked line", 1'b0, 3'd0);
    en = 5'b01000; #1;
    chk("R11 unmasked later", 1'b1, 3'd1);
    lsr_rd = 1'b1; step(); lsr_rd = 1'b0;

    // receive timeout, 10-bit frames -> 40 ticks
    en = 5'b00001; fifo_en = 1'b1; trig = 5'd8; cnt = 5'd3; frame_bits = 4'd10;
    fifo_wr = 1'b1; step(); fifo_wr = 1'b0;
    tick = 1'b1;
    for (int i = 0; i < 30; i++) step();
    tick = 1'b0; fifo_wr = 1'b1; step(); fifo_wr = 1'b0;
    tick = 1'b1;
    for (int i = 0; i < 39; i++) step();
    tick = 1'b0; step();
    chk("R6 restart by access, 39 ticks", 1'b0, 3'd0);
    tick = 1'b1; step(); tick = 1'b0;
    chk("R6 not before next edge", 1'b0, 3'd0);
    step();
    chk("R6 timeout raised", 1'b1, 3'd3);
    rbr_rd = 1'b1; cnt = 5'd2; step(); rbr_rd = 1'b0;
    chk("R7 held across read", 1'b1, 3'd3);
    cnt = 5'd1; step();
    chk("R7 held while not empty", 1'b1, 3'd3);
    cnt = 5'd0; step();
    chk("R7 cleared when empty", 1'b0, 3'd0);

    summary();
    $finish;
  end
endmodule